// File: doc/BRIEF.md
# Debug Scan Ring Controller

This block threads the test-point registers of several modules under test into one serial loop that a host reaches 32 bits at a time over a simple register port. Each DWORD the host writes to the shift address enters the loop. The loop then advances by 32 positions over 32 clock cycles, and the 32 bits that fall off the far end are held in a read register. An exchange command swaps the loop with the test points in one step. Capture values go into the loop, and the old loop contents are driven onto the write-side test-point outputs.

Each shift or exchange that finishes advances a 6-bit sequence number. The host polls this number before it reads each DWORD. A status control register selects how the reported sequence value is updated. In automatic mode the reported value follows the counter. In any other mode it stays frozen, but a control write of mode 1 or 2 takes a single snapshot. The loop is `RING_DWORDS` DWORDs long. The host can find this length by writing a marker word and counting the shifts until the marker comes back.

Top module: `dbg_ring_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `rd_data`, `status_seq` and `tp_drive` are all zero, `ready` is 1, and the loop holds zeros.
- R2: A host write to address 0 pushes the written DWORD into the loop and puts the 32 bits that leave it into `rd_data`. The loop is ordered LSB-first, so a DWORD written now returns on `rd_data` after exactly `RING_DWORDS` further shifts. A marker such as 0xFFFFFFFF can therefore reveal the loop length.
- R3: After a shift is accepted, `ready` is 0 for exactly 33 cycles: 32 bit cycles and one completion cycle. Shift and exchange commands that arrive while `ready` is 0 have no effect.
- R4: A host write to address 1 while `ready` is 1 copies the loop onto `tp_drive` and loads `tp_capture` into the loop in the same cycle. Bit k of the loop maps to bit k of both buses. `ready` is then 0 for one cycle.
- R5: With no shifts beforehand, an exchange followed by `RING_DWORDS` shifts returns the captured DWORDs on `rd_data` in order, starting with bits 31:0.
- R6: Every completed shift or exchange adds exactly 1 to the 6-bit sequence number, which wraps modulo 64.
- R7: The status mode is written through address 2, using bits 1:0 of the data. In mode 3, `status_seq` takes the sequence number one cycle after it changes. In any other mode, `status_seq` holds its value.
- R8: A control write with mode value 1 or 2 copies the current sequence number into `status_seq` once.
- R9: A write to address 3 has no effect on the loop, `ready`, `rd_data` or the sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select: 0 shift, 1 exchange, 2 status mode, 3 unused |
| host_wdata | input | 32 | Host write data |
| rd_data | output | 32 | DWORD most recently shifted out of the loop |
| status_seq | output | 6 | Reported sequence number |
| ready | output | 1 | High when a shift or exchange command can be accepted |
| tp_capture | input | 32*RING_DWORDS | Test-point values sampled by an exchange |
| tp_drive | output | 32*RING_DWORDS | Write-side test-point values set by an exchange |

## Verification
The assertions check the following on every cycle:
- an accepted shift drops `ready` on the next cycle;
- an exchange drives the previous loop contents onto `tp_drive`;
- the sequence counter moves only by one, and only after a completion;
- the reported status stays frozen outside automatic mode and tracks the counter inside it.

Some behaviours need the bench's scenarios:
- the order of the DWORDs through the loop and the round trip of the marker;
- the exact 33-cycle busy window;
- the rejection of commands that arrive while busy;
- the single-shot snapshot and the wrap at 64.

// File: rtl/dbg_ring_pkg.sv
// Shared constants for the debug scan ring controller.
// Assumes a 32-bit host data path and a 2-bit register select.
package dbg_ring_pkg;
    localparam int DW = 32;
    localparam logic [1:0] ADR_SHIFT = 2'd0;
    localparam logic [1:0] ADR_XCHG  = 2'd1;
    localparam logic [1:0] ADR_MODE  = 2'd2;
    localparam logic [1:0] MODE_AUTO = 2'd3;
endpackage

// File: rtl/dbg_ring_stage.sv
// One DWORD segment of the scan loop. It shifts one bit toward its LSB per
// enabled cycle (serial in at the MSB) and swaps with its test points on load.
// Assumes that load and shift are never asserted together.
module dbg_ring_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         load_en,
    input  logic         sin,
    input  logic [W-1:0] cap,
    output logic         sout,
    output logic [W-1:0] drive,
    output logic [W-1:0] val
);
    logic [W-1:0] sh_q;
    logic [W-1:0] drv_q;

    // Segment register: exchange with the test points, or shift by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            drv_q <= '0;
        end else if (load_en) begin
            drv_q <= sh_q;
            sh_q  <= cap;
        end else if (shift_en) begin
            sh_q <= {sin, sh_q[W-1:1]};
        end
    end

    assign sout  = sh_q[0];
    assign drive = drv_q;
    assign val   = sh_q;
endmodule

// File: rtl/dbg_ring_seq.sv
// Sequencer for shift and exchange operations. A shift runs for DW bit cycles
// under a bit counter. Each operation ends with a one-cycle done pulse, and
// ready is low while the sequencer is busy or the done pulse is pending.
// Assumes the go inputs are only raised while ready is high.
module dbg_ring_seq
    import dbg_ring_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_go,
    input  logic          load_go,
    input  logic [DW-1:0] wdata,
    input  logic          ring_out,
    output logic          shift_en,
    output logic          in_bit,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          ready
);
    localparam int CNT_W = $clog2(DW);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    sbuf_q;
    logic [DW-1:0]    obuf_q;
    logic [DW-1:0]    rd_q;

    // Operation control: start a shift, step it bit by bit, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            sbuf_q <= '0;
            obuf_q <= '0;
            rd_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (shift_go) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                sbuf_q <= wdata;
            end else if (busy_q) begin
                sbuf_q <= sbuf_q >> 1;
                obuf_q <= {ring_out, obuf_q[DW-1:1]};
                cnt_q  <= cnt_q + CNT_W'(1);
                if (cnt_q == CNT_W'(DW - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    rd_q   <= {ring_out, obuf_q[DW-1:1]};
                end
            end else if (load_go) begin
                done_q <= 1'b1;
            end
        end
    end

    assign shift_en = busy_q;
    assign in_bit   = sbuf_q[0];
    assign rd_data  = rd_q;
    assign done     = done_q;
    assign ready    = !busy_q && !done_q;
endmodule

// File: rtl/dbg_ring_status.sv
// Sequence counter and reported status. The counter advances on each done
// pulse. The reported value follows it in automatic mode, is frozen in the
// other modes, and takes a single snapshot on a control write of mode 1 or 2.
module dbg_ring_status
    import dbg_ring_pkg::*;
#(
    parameter int SEQ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             ctrl_we,
    input  logic [1:0]       ctrl_mode,
    output logic [SEQ_W-1:0] seq_cnt,
    output logic [1:0]       mode,
    output logic [SEQ_W-1:0] status_seq
);
    logic [SEQ_W-1:0] seq_q;
    logic [SEQ_W-1:0] stat_q;
    logic [1:0]       mode_q;

    // Counter of completed operations, modulo 2**SEQ_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    seq_q <= '0;
        else if (done) seq_q <= seq_q + SEQ_W'(1);
    end

    // Status mode register, written from the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 2'd0;
        else if (ctrl_we) mode_q <= ctrl_mode;
    end

    // Reported value: single-shot snapshot, or continuous in automatic mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (ctrl_we && (ctrl_mode == 2'd1 || ctrl_mode == 2'd2)) begin
            stat_q <= seq_q;
        end else if (mode_q == MODE_AUTO) begin
            stat_q <= seq_q;
        end
    end

    assign seq_cnt    = seq_q;
    assign mode       = mode_q;
    assign status_seq = stat_q;
endmodule

// File: rtl/dbg_ring_ctrl.sv
// Top of the debug scan ring controller. It decodes host writes, runs the
// sequencer, and chains RING_DWORDS segments into one loop. The host bit
// enters the top segment, and the loop output leaves segment 0's LSB.
// Assumes single-cycle host write strobes that are synchronous to clk.
module dbg_ring_ctrl
    import dbg_ring_pkg::*;
#(
    parameter int RING_DWORDS = 4,
    parameter int SEQ_W       = 6,
    localparam int RING_BITS  = RING_DWORDS * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [1:0]           host_addr,
    input  logic [DW-1:0]        host_wdata,
    output logic [DW-1:0]        rd_data,
    output logic [SEQ_W-1:0]     status_seq,
    output logic                 ready,
    input  logic [RING_BITS-1:0] tp_capture,
    output logic [RING_BITS-1:0] tp_drive
);
    logic                 shift_go;
    logic                 load_go;
    logic                 ctrl_we;
    logic                 shift_en;
    logic                 in_bit;
    logic                 done;
    logic [SEQ_W-1:0]     seq_cnt;
    logic [1:0]           mode;
    logic [RING_DWORDS:0] link;
    logic [RING_BITS-1:0] ring_bits;

    // Command decode; shift and exchange are accepted only while ready.
    always_comb begin
        shift_go = host_we && host_addr == ADR_SHIFT && ready;
        load_go  = host_we && host_addr == ADR_XCHG  && ready;
        ctrl_we  = host_we && host_addr == ADR_MODE;
    end

    dbg_ring_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_go (shift_go),
        .load_go  (load_go),
        .wdata    (host_wdata),
        .ring_out (link[0]),
        .shift_en (shift_en),
        .in_bit   (in_bit),
        .rd_data  (rd_data),
        .done     (done),
        .ready    (ready)
    );

    assign link[RING_DWORDS] = in_bit;

    for (genvar g = 0; g < RING_DWORDS; g++) begin : g_stage
        dbg_ring_stage #(.W(DW)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .load_en  (load_go),
            .sin      (link[g+1]),
            .cap      (tp_capture[g*DW +: DW]),
            .sout     (link[g]),
            .drive    (tp_drive[g*DW +: DW]),
            .val      (ring_bits[g*DW +: DW])
        );
    end

    dbg_ring_status #(.SEQ_W(SEQ_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .ctrl_we    (ctrl_we),
        .ctrl_mode  (host_wdata[1:0]),
        .seq_cnt    (seq_cnt),
        .mode       (mode),
        .status_seq (status_seq)
    );
endmodule

// File: rtl/dbg_ring_ctrl_chk.sv
// Checker for dbg_ring_ctrl, attached with bind. It relates the command
// ports, the loop, the sequence counter and the reported status over time.
module dbg_ring_ctrl_chk #(
    parameter int RING_BITS = 128,
    parameter int SEQ_W     = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_we,
    input logic [1:0]           host_addr,
    input logic                 ready,
    input logic                 done,
    input logic [SEQ_W-1:0]     seq_cnt,
    input logic [1:0]           mode,
    input logic [SEQ_W-1:0]     status_seq,
    input logic [RING_BITS-1:0] ring_bits,
    input logic [RING_BITS-1:0] tp_drive
);
    // R3: an accepted shift makes the block busy on the next cycle.
    a_r3_shift_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 2'd0 && ready) |=> !ready);

    // R4: an exchange drives the previous loop contents onto the test points.
    a_r4_exchange_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 2'd1 && ready) |=> (tp_drive == $past(ring_bits)));

    // R6: completion adds exactly one to the sequence number.
    a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (seq_cnt == $past(seq_cnt) + SEQ_W'(1)));

    // R6: no completion, no change of the sequence number.
    a_r6_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(seq_cnt));

    // R7: outside automatic mode, with no control write, status is frozen.
    a_r7_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd3 && !(host_we && host_addr == 2'd2)) |=> $stable(status_seq));

    // R7: in automatic mode, status takes the counter one cycle later.
    a_r7_status_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && !(host_we && host_addr == 2'd2)) |=> (status_seq == $past(seq_cnt)));
endmodule

bind dbg_ring_ctrl dbg_ring_ctrl_chk #(
    .RING_BITS (RING_BITS),
    .SEQ_W     (SEQ_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .ready      (ready),
    .done       (done),
    .seq_cnt    (seq_cnt),
    .mode       (mode),
    .status_seq (status_seq),
    .ring_bits  (ring_bits),
    .tp_drive   (tp_drive)
);

// File: tb/dbg_ring_ctrl_bench.sv
// Bench for dbg_ring_ctrl: a table of shift vectors walked by one loop,
// then directed tests for timing, exchange, status modes and wrap.
module dbg_ring_ctrl_bench;
    localparam int N  = 4;
    localparam int RB = N * 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_we;
    logic [1:0]    host_addr;
    logic [31:0]   host_wdata;
    logic [31:0]   rd_data;
    logic [5:0]    status_seq;
    logic          ready;
    logic [RB-1:0] tp_capture;
    logic [RB-1:0] tp_drive;

    int n_run  = 0;
    int n_fail = 0;

    logic [31:0]   mdl [N];
    logic [5:0]    exp_seq;
    logic [31:0]   mout;
    logic [RB-1:0] mcat;

    // {write data, expected rd_data}; the loop starts all zero after reset.
    localparam logic [63:0] TBL [8] = '{
        {32'hA5A5_0001, 32'h0000_0000},
        {32'h5A5A_0002, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0000},
        {32'h0000_0000, 32'h0000_0000},
        {32'h1234_5678, 32'hA5A5_0001},
        {32'h8000_0001, 32'h5A5A_0002},
        {32'hDEAD_BEEF, 32'hFFFF_FFFF},
        {32'h0F0F_F0F0, 32'h0000_0000}
    };

    always #10 clk = ~clk;

    dbg_ring_ctrl #(.RING_DWORDS(N), .SEQ_W(6)) u_dbg_ring_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rd_data    (rd_data),
        .status_seq (status_seq),
        .ready      (ready),
        .tp_capture (tp_capture),
        .tp_drive   (tp_drive)
    );

    task automatic chk(input string req, input logic [RB-1:0] act, input logic [RB-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Wait until ready, then one more cycle for the status update.
    task automatic wait_op();
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic model_shift(input logic [31:0] d);
        mout = mdl[0];
        for (int k = 0; k < N - 1; k++) mdl[k] = mdl[k+1];
        mdl[N-1] = d;
    endtask

    task automatic model_cat();
        for (int k = 0; k < N; k++) mcat[k*32 +: 32] = mdl[k];
    endtask

    task automatic model_xchg();
        model_cat();
        for (int k = 0; k < N; k++) mdl[k] = tp_capture[k*32 +: 32];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] s0;
        int busy_cnt;
        rst_n = 1'b0; host_we = 1'b0; host_addr = 2'd0; host_wdata = '0;
        for (int k = 0; k < N; k++) begin
            mdl[k] = '0;
            tp_capture[k*32 +: 32] = 32'hC0DE_0000 + 32'(k) * 32'h0001_0101;
        end
        exp_seq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rd_data", RB'(rd_data), '0);
        chk("R1 status_seq", RB'(status_seq), '0);
        chk("R1 tp_drive", tp_drive, '0);
        chk("R1 ready", RB'(ready), RB'(1));

        // R7: select automatic status mode
        host_write(2'd2, 32'd3);
        @(negedge clk);

        // R2, R6: table walk, marker 0xFFFFFFFF returns after N shifts
        for (int i = 0; i < 8; i++) begin
            host_write(2'd0, TBL[i][63:32]);
            wait_op();
            model_shift(TBL[i][63:32]);
            exp_seq++;
            chk("R2 shifted-out DWORD", RB'(rd_data), RB'(TBL[i][31:0]));
            chk("R6 sequence after shift", RB'(status_seq), RB'(exp_seq));
        end

        // R3: ready low for 33 cycles after an accepted shift
        host_write(2'd0, 32'h1357_9BDF);
        busy_cnt = 0;
        while (!ready) begin busy_cnt++; @(negedge clk); end
        @(negedge clk);
        model_shift(32'h1357_9BDF); exp_seq++;
        chk("R3 busy cycles", RB'(busy_cnt), RB'(33));
        chk("R2 rd after timed shift", RB'(rd_data), RB'(mout));

        // R3: commands while busy are dropped
        host_write(2'd0, 32'h2468_ACE0);
        host_write(2'd1, 32'd0);
        host_write(2'd0, 32'hFFFF_FFFF);
        wait_op();
        model_shift(32'h2468_ACE0); exp_seq++;
        chk("R3 one completion only", RB'(status_seq), RB'(exp_seq));
        chk("R3 dropped exchange", tp_drive, '0);
        host_write(2'd0, 32'h0);
        wait_op(); model_shift(32'h0); exp_seq++;
        chk("R3 dropped shift left loop intact", RB'(rd_data), RB'(mout));

        // R4: exchange
        host_write(2'd1, 32'd0);
        wait_op();
        model_xchg(); exp_seq++;
        chk("R4 tp_drive from loop", tp_drive, mcat);
        chk("R6 sequence after exchange", RB'(status_seq), RB'(exp_seq));

        // R5: read back the captured DWORDs, lowest first
        for (int i = 0; i < N; i++) begin
            host_write(2'd0, 32'h0);
            wait_op(); model_shift(32'h0); exp_seq++;
            chk("R5 captured DWORD", RB'(rd_data), RB'(tp_capture[i*32 +: 32]));
        end

        // R9: address 3 has no effect
        host_write(2'd3, 32'hFFFF_FFFF);
        chk("R9 ready unchanged", RB'(ready), RB'(1));
        @(negedge clk);
        chk("R9 sequence unchanged", RB'(status_seq), RB'(exp_seq));
        host_write(2'd0, 32'hABCD_0123);
        wait_op(); model_shift(32'hABCD_0123); exp_seq++;
        chk("R9 loop unchanged", RB'(rd_data), RB'(mout));

        // R7: mode 0 freezes status
        s0 = exp_seq;
        host_write(2'd2, 32'd0);
        host_write(2'd1, 32'd0);
        wait_op(); model_xchg(); exp_seq++;
        chk("R7 frozen in mode 0", RB'(status_seq), RB'(s0));
        chk("R4 tp_drive second exchange", tp_drive, mcat);

        // R8: single-shot snapshots with mode 1 and 2
        host_write(2'd2, 32'd1);
        chk("R8 snapshot mode 1", RB'(status_seq), RB'(exp_seq));
        host_write(2'd1, 32'd0);
        wait_op(); model_xchg(); exp_seq++;
        chk("R7 frozen in mode 1", RB'(status_seq), RB'(exp_seq - 6'd1));
        host_write(2'd2, 32'd2);
        chk("R8 snapshot mode 2", RB'(status_seq), RB'(exp_seq));

        // R6: wrap modulo 64
        host_write(2'd2, 32'd3);
        @(negedge clk);
        s0 = status_seq;
        for (int i = 0; i < 64; i++) begin
            host_write(2'd1, 32'd0);
            wait_op();
        end
        chk("R6 wrap after 64 operations", RB'(status_seq), RB'(s0));

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule